// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs external bus cycles for a processor core whose address and data share one pin group. The core presents a request with a 20-bit address, a read/write flag, a memory/I/O flag and 16 bits of write data. The block latches the request. It drives the address with a one-clock latch pulse, then either floats the shared pins to let the addressed device answer or drives the write data onto them. Along the way it produces active-low read and write strobes, a 3-bit cycle status code, and enable and direction controls for external bus transceivers.

A cycle is at least four clocks long. A ready input, sampled at the end of the third clock and at the end of each inserted wait clock, stretches the cycle for as long as it stays low. Another bus master can ask for the bus with a hold request. The request is granted only between cycles. While it is granted, every bus output is floated and the acknowledge is high. The core regains the bus one clock after the request is withdrawn.

The state machine has seven states. S_IDLE goes to S_T1 on an accepted request and to S_HOLD on a hold request. S_T1 goes to S_T2, and S_T2 goes to S_T3. S_T3 goes to S_T4 when ready is high and to S_TW when it is low. S_TW loops on itself until ready is high, then goes to S_T4. S_T4 goes to S_HOLD, to S_T1 or to S_IDLE, with the same priority as S_IDLE. S_HOLD goes back to S_IDLE when the hold request drops.

Top module: `mux_bus_sequencer`

## Requirements
- R1: After reset, and before any request, the outputs are idle. Both strobes are high, the address strobe is low, the transceiver enable is low, the status is passive (3'b111), the grant is low, both data output enables are low and the control enable is high.
- R2: `req_accept` is high in any clock where `req_valid` is high, the state is idle or T4, and `bus_req_i` is low. The request's T1 follows at the next clock. The request fields are latched at that edge, so later changes on the request inputs do not affect the cycle.
- R3: In T1, `addr_strobe_o` is high for exactly one clock. `ad_o` carries address bits 15:0 and `addr_hi_o` carries bits 19:16, with both enables high. The transceiver enable is low.
- R4: In a read, `ad_oe` is low from T2 through T4. `rd_strobe_n_o` is low in T2, T3 and every wait clock. `xcvr_dir_o` is low for the whole cycle.
- R5: In a write, `ad_o` carries the write data with `ad_oe` high from T2 through T4. `wr_strobe_n_o` is low in T2, T3 and every wait clock. `xcvr_dir_o` is high for the whole cycle.
- R6: `cyc_ready_i` is ignored in T2. Each low sample at the end of T3 or of a wait clock adds one wait clock, during which the strobe stays low and the status holds its code.
- R7: In a read, `rsp_rdata` holds the value of `ad_i` at the edge where ready was sampled high. `rsp_done` is high for exactly the T4 clock of every cycle.
- R8: `xcvr_en_o` is high in T2, T3, the wait clocks and T4 only, and never at the same time as `addr_strobe_o`.
- R9: From T1 through the last wait clock, `status_o` shows the cycle kind: memory read 3'b101, memory write 3'b110, I/O read 3'b001, I/O write 3'b010. In T4 and at all other times it shows passive 3'b111.
- R10: A hold request is honoured only in idle or T4. `bus_grant_o` rises at the next clock. While it is high, `ad_oe`, `addr_hi_oe` and `ctrl_oe` are low and `req_accept` is low. A hold request raised in the middle of a cycle waits for that cycle to finish.
- R11: One clock after `bus_req_i` drops, `bus_grant_o` is low, the outputs are in the idle state and a pending request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_accept | output | 1 | Request taken this clock |
| rsp_done | output | 1 | Cycle in its final clock |
| rsp_rdata | output | 16 | Captured read data |
| ad_o | output | 16 | Shared address/data pins, outgoing value |
| ad_i | input | 16 | Shared address/data pins, incoming value |
| ad_oe | output | 16 | Drive enable for the shared pins (all bits equal) |
| addr_hi_o | output | 4 | Upper address bits |
| addr_hi_oe | output | 1 | Drive enable for upper address bits |
| addr_strobe_o | output | 1 | Address latch pulse |
| rd_strobe_n_o | output | 1 | Read strobe, active low |
| wr_strobe_n_o | output | 1 | Write strobe, active low |
| xcvr_en_o | output | 1 | Transceiver enable |
| xcvr_dir_o | output | 1 | Transceiver direction, 1 = outbound |
| status_o | output | 3 | Cycle status code |
| ctrl_oe | output | 1 | Drive enable for strobes, status and transceiver controls |
| cyc_ready_i | input | 1 | Ready from the addressed device |
| bus_req_i | input | 1 | Hold request from another master |
| bus_grant_o | output | 1 | Hold acknowledge |

## Verification
A wrong state or a wrong transition shows at the ports within the same clock. The strobes, address strobe, transceiver enable and status are all decoded from the current state, so a skipped wait clock or a missing wait clock shortens or lengthens the strobe by one clock at once. A corrupted request latch shows as a wrong address in T1, wrong write data in T2, or a wrong status code. A grant given in the middle of a cycle shows as the enables dropping while a strobe is still low. Each clock of every cycle is compared against a bench model of the expected timeline, with random and directed wait counts and hold timing.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_T1,
        S_T2,
        S_T3,
        S_TW,
        S_T4,
        S_HOLD
    } bus_state_e;

    localparam logic [2:0] ST_PASSIVE = 3'b111;

    // bit2: memory space, bits1:0: 01 read, 10 write
    function automatic logic [2:0] status_code(input logic is_write, input logic is_io);
        return {~is_io, is_write ? 2'b10 : 2'b01};
    endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
    import bus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_req_i,
    input  logic       cyc_ready_i,
    output bus_state_e state,
    output logic       req_accept
);

    bus_state_e state_nx;
    logic       boundary;

    assign boundary   = (state == S_IDLE) || (state == S_T4);
    assign req_accept = boundary && !bus_req_i && req_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE, S_T4: begin
                if (bus_req_i)      state_nx = S_HOLD;
                else if (req_valid) state_nx = S_T1;
                else                state_nx = S_IDLE;
            end
            S_T1:   state_nx = S_T2;
            S_T2:   state_nx = S_T3;
            S_T3, S_TW: state_nx = cyc_ready_i ? S_T4 : S_TW;
            S_HOLD: state_nx = bus_req_i ? S_HOLD : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

endmodule

// File: rtl/bus_seq_latch.sv
module bus_seq_latch
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              req_accept,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_i,
    input  logic              cyc_ready_i,
    output logic              cur_write,
    output logic              cur_io,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic sample_edge;
    assign sample_edge = ((state == S_T3) || (state == S_TW)) && cyc_ready_i && !cur_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_io    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (req_accept) begin
            cur_write <= req_write;
            cur_io    <= req_io;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           rsp_rdata <= '0;
        else if (sample_edge) rsp_rdata <= ad_i;
    end

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  bus_state_e        state,
    input  logic              cur_write,
    input  logic              cur_io,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] ad_o,
    output logic [DATA_W-1:0] ad_oe,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic              addr_hi_oe,
    output logic              addr_strobe_o,
    output logic              rd_strobe_n_o,
    output logic              wr_strobe_n_o,
    output logic              xcvr_en_o,
    output logic              xcvr_dir_o,
    output logic [2:0]        status_o,
    output logic              ctrl_oe,
    output logic              bus_grant_o,
    output logic              rsp_done
);

    always_comb begin
        ad_o          = '0;
        ad_oe         = '0;
        addr_hi_o     = cur_addr[ADDR_W-1:DATA_W];
        addr_hi_oe    = 1'b0;
        addr_strobe_o = 1'b0;
        rd_strobe_n_o = 1'b1;
        wr_strobe_n_o = 1'b1;
        xcvr_en_o     = 1'b0;
        xcvr_dir_o    = 1'b0;
        status_o      = ST_PASSIVE;
        ctrl_oe       = 1'b1;
        bus_grant_o   = 1'b0;
        rsp_done      = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_T1: begin
                ad_o          = cur_addr[DATA_W-1:0];
                ad_oe         = '1;
                addr_hi_oe    = 1'b1;
                addr_strobe_o = 1'b1;
                xcvr_dir_o    = cur_write;
                status_o      = status_code(cur_write, cur_io);
            end
            S_T2, S_T3, S_TW: begin
                ad_o          = cur_write ? cur_wdata : '0;
                ad_oe         = {DATA_W{cur_write}};
                addr_hi_oe    = 1'b1;
                rd_strobe_n_o = cur_write;
                wr_strobe_n_o = !cur_write;
                xcvr_en_o     = 1'b1;
                xcvr_dir_o    = cur_write;
                status_o      = status_code(cur_write, cur_io);
            end
            S_T4: begin
                ad_o       = cur_write ? cur_wdata : '0;
                ad_oe      = {DATA_W{cur_write}};
                addr_hi_oe = 1'b1;
                xcvr_en_o  = 1'b1;
                xcvr_dir_o = cur_write;
                rsp_done   = 1'b1;
            end
            S_HOLD: begin
                ctrl_oe     = 1'b0;
                bus_grant_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_accept,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] ad_o,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_oe,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic              addr_hi_oe,
    output logic              addr_strobe_o,
    output logic              rd_strobe_n_o,
    output logic              wr_strobe_n_o,
    output logic              xcvr_en_o,
    output logic              xcvr_dir_o,
    output logic [2:0]        status_o,
    output logic              ctrl_oe,
    input  logic              cyc_ready_i,
    input  logic              bus_req_i,
    output logic              bus_grant_o
);

    bus_state_e        state;
    logic              cur_write;
    logic              cur_io;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    bus_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .bus_req_i   (bus_req_i),
        .cyc_ready_i (cyc_ready_i),
        .state       (state),
        .req_accept  (req_accept)
    );

    bus_seq_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .req_accept  (req_accept),
        .req_write   (req_write),
        .req_io      (req_io),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .ad_i        (ad_i),
        .cyc_ready_i (cyc_ready_i),
        .cur_write   (cur_write),
        .cur_io      (cur_io),
        .cur_addr    (cur_addr),
        .cur_wdata   (cur_wdata),
        .rsp_rdata   (rsp_rdata)
    );

    bus_seq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .state         (state),
        .cur_write     (cur_write),
        .cur_io        (cur_io),
        .cur_addr      (cur_addr),
        .cur_wdata     (cur_wdata),
        .ad_o          (ad_o),
        .ad_oe         (ad_oe),
        .addr_hi_o     (addr_hi_o),
        .addr_hi_oe    (addr_hi_oe),
        .addr_strobe_o (addr_strobe_o),
        .rd_strobe_n_o (rd_strobe_n_o),
        .wr_strobe_n_o (wr_strobe_n_o),
        .xcvr_en_o     (xcvr_en_o),
        .xcvr_dir_o    (xcvr_dir_o),
        .status_o      (status_o),
        .ctrl_oe       (ctrl_oe),
        .bus_grant_o   (bus_grant_o),
        .rsp_done      (rsp_done)
    );

endmodule

// File: rtl/mux_bus_sequencer_checker.sv
module mux_bus_sequencer_checker (
    input logic clk,
    input logic rst_n,
    input logic req_accept,
    input logic rsp_done,
    input logic ad_oe0,
    input logic addr_hi_oe,
    input logic addr_strobe_o,
    input logic rd_strobe_n_o,
    input logic wr_strobe_n_o,
    input logic xcvr_en_o,
    input logic xcvr_dir_o,
    input logic ctrl_oe,
    input logic cyc_ready_i,
    input logic bus_grant_o
);

    AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe_o |=> !addr_strobe_o); // R3
    AST_NO_OVERLAP_EN_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe_o |-> !xcvr_en_o); // R8
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_strobe_n_o && !wr_strobe_n_o)); // R4
    AST_READ_DIR_IN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_n_o |-> !xcvr_dir_o); // R4
    AST_WRITE_DIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe_n_o |-> xcvr_dir_o); // R5
    AST_WAIT_KEEPS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe_n_o && !cyc_ready_i) |=> !rd_strobe_n_o); // R6
    AST_WAIT_KEEPS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_strobe_n_o && !cyc_ready_i) |=> !wr_strobe_n_o); // R6
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(!rd_strobe_n_o || !wr_strobe_n_o)); // R7
    AST_GRANT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant_o |-> (!ad_oe0 && !addr_hi_oe && !ctrl_oe && !req_accept)); // R10
    AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant_o) |-> $past(rd_strobe_n_o && wr_strobe_n_o && !addr_strobe_o)); // R10

endmodule

bind mux_bus_sequencer mux_bus_sequencer_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_accept    (req_accept),
    .rsp_done      (rsp_done),
    .ad_oe0        (ad_oe[0]),
    .addr_hi_oe    (addr_hi_oe),
    .addr_strobe_o (addr_strobe_o),
    .rd_strobe_n_o (rd_strobe_n_o),
    .wr_strobe_n_o (wr_strobe_n_o),
    .xcvr_en_o     (xcvr_en_o),
    .xcvr_dir_o    (xcvr_dir_o),
    .ctrl_oe       (ctrl_oe),
    .cyc_ready_i   (cyc_ready_i),
    .bus_grant_o   (bus_grant_o)
);

// File: tb/mux_bus_sequencer_bench.sv
module mux_bus_sequencer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_accept, rsp_done;
    logic [15:0] rsp_rdata, ad_o, ad_oe;
    logic [15:0] ad_i = '0;
    logic [3:0]  addr_hi_o;
    logic        addr_hi_oe, addr_strobe_o, rd_strobe_n_o, wr_strobe_n_o;
    logic        xcvr_en_o, xcvr_dir_o, ctrl_oe, bus_grant_o;
    logic [2:0]  status_o;
    logic        cyc_ready_i = 1'b0, bus_req_i = 1'b0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_sequencer u_mux_bus_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_accept(req_accept), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ad_o(ad_o), .ad_i(ad_i), .ad_oe(ad_oe), .addr_hi_o(addr_hi_o),
        .addr_hi_oe(addr_hi_oe), .addr_strobe_o(addr_strobe_o),
        .rd_strobe_n_o(rd_strobe_n_o), .wr_strobe_n_o(wr_strobe_n_o),
        .xcvr_en_o(xcvr_en_o), .xcvr_dir_o(xcvr_dir_o), .status_o(status_o),
        .ctrl_oe(ctrl_oe), .cyc_ready_i(cyc_ready_i), .bus_req_i(bus_req_i),
        .bus_grant_o(bus_grant_o)
    );

    function automatic logic [2:0] exp_status(input logic w, input logic io);
        if (!io) return w ? 3'b110 : 3'b101;
        else     return w ? 3'b010 : 3'b001;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " R1 rd"}, rd_strobe_n_o, 1);
        chk({tag, " R1 wr"}, wr_strobe_n_o, 1);
        chk({tag, " R1 ale"}, addr_strobe_o, 0);
        chk({tag, " R8 en"}, xcvr_en_o, 0);
        chk({tag, " R9 status"}, status_o, 3'b111);
        chk({tag, " R11 grant"}, bus_grant_o, 0);
        chk({tag, " R1 ad_oe"}, ad_oe, 0);
        chk({tag, " R1 hi_oe"}, addr_hi_oe, 0);
        chk({tag, " R1 ctrl_oe"}, ctrl_oe, 1);
        chk({tag, " R7 done"}, rsp_done, 0);
    endtask

    // Starts at a negedge in idle; ends at the negedge after T4.
    task automatic run_cycle(input logic w, input logic io, input logic [19:0] a,
                             input logic [15:0] d, input int waits,
                             input logic [15:0] rd, input logic hold_mid);
        logic [2:0] st;
        st = exp_status(w, io);
        req_valid = 1; req_write = w; req_io = io; req_addr = a; req_wdata = d;
        #1 chk("R2 accept", req_accept, 1);
        @(negedge clk); // T1
        req_valid = 0; req_write = ~w; req_io = ~io; req_addr = ~a; req_wdata = ~d;
        chk("R3 ale", addr_strobe_o, 1);
        chk("R3 ad_o", ad_o, a[15:0]);
        chk("R3 hi", addr_hi_o, a[19:16]);
        chk("R3 oe", {ad_oe[0], addr_hi_oe}, 2'b11);
        chk("R8 en T1", xcvr_en_o, 0);
        chk("R9 status T1", status_o, st);
        chk("R4_R5 dir T1", xcvr_dir_o, w);
        chk("R2 no accept T1", req_accept, 0);
        @(negedge clk); // T2
        if (hold_mid) bus_req_i = 1;
        cyc_ready_i = 0;
        chk("R3 ale low T2", addr_strobe_o, 0);
        chk("R8 en T2", xcvr_en_o, 1);
        chk("R4_R5 ad_oe T2", ad_oe, w ? 16'hFFFF : 16'h0000);
        if (w) chk("R5 wdata T2", ad_o, d);
        chk("R4 rd T2", rd_strobe_n_o, w);
        chk("R5 wr T2", wr_strobe_n_o, !w);
        chk("R9 status T2", status_o, st);
        @(negedge clk); // T3
        chk("R6 strobe T3", {rd_strobe_n_o, wr_strobe_n_o}, {w, !w});
        chk("R4_R5 dir T3", xcvr_dir_o, w);
        chk("R10 no grant T3", bus_grant_o, 0);
        cyc_ready_i = (waits == 0);
        ad_i = cyc_ready_i ? rd : ~rd;
        for (int i = 0; i < waits; i++) begin
            @(negedge clk); // Tw
            chk("R6 strobe Tw", {rd_strobe_n_o, wr_strobe_n_o}, {w, !w});
            chk("R6 status Tw", status_o, st);
            chk("R6 no done Tw", rsp_done, 0);
            cyc_ready_i = (i == waits - 1);
            ad_i = cyc_ready_i ? rd : ~rd;
        end
        @(negedge clk); // T4
        cyc_ready_i = 0;
        ad_i = 16'h0;
        chk("R7 done T4", rsp_done, 1);
        chk("R6 strobes off T4", {rd_strobe_n_o, wr_strobe_n_o}, 2'b11);
        chk("R9 passive T4", status_o, 3'b111);
        chk("R8 en T4", xcvr_en_o, 1);
        chk("R4_R5 ad_oe T4", ad_oe[0], w);
        chk("R10 no grant T4", bus_grant_o, 0);
        if (!w) chk("R7 rdata", rsp_rdata, rd);
        else    chk("R5 wdata T4", ad_o, d);
        @(negedge clk);
        if (hold_mid) begin
            chk("R10 grant after cycle", bus_grant_o, 1);
            chk("R10 floated", {ad_oe[0], addr_hi_oe, ctrl_oe}, 3'b000);
            bus_req_i = 0;
            @(negedge clk);
            chk("R11 resume", bus_grant_o, 0);
        end
        chk_idle("post");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_idle("reset");

        // directed corners
        run_cycle(0, 0, 20'hABCDE, 16'h0000, 0, 16'h1234, 0);
        run_cycle(1, 0, 20'h5A5A5, 16'hBEEF, 0, 16'h0000, 0);
        run_cycle(0, 1, 20'h00FF0, 16'h0000, 3, 16'hC0DE, 0);
        run_cycle(1, 1, 20'hFFFFF, 16'h8001, 5, 16'h0000, 0);
        run_cycle(0, 0, 20'h12345, 16'h0000, 1, 16'h7777, 1);

        // hold in idle with a request pending
        bus_req_i = 1; req_valid = 1; req_write = 0; req_io = 0;
        #1 chk("R10 accept blocked", req_accept, 0);
        @(negedge clk);
        chk("R10 grant", bus_grant_o, 1);
        chk("R10 floated", {ad_oe[0], addr_hi_oe, ctrl_oe}, 3'b000);
        chk("R10 no accept", req_accept, 0);
        @(negedge clk);
        chk("R10 grant held", bus_grant_o, 1);
        bus_req_i = 0;
        #1 chk("R11 still held", req_accept, 0);
        @(negedge clk);
        chk("R11 grant low", bus_grant_o, 0);
        chk("R11 ctrl_oe", ctrl_oe, 1);
        #1 chk("R11 accept", req_accept, 1);
        req_valid = 0;
        #1;
        @(negedge clk);
        chk_idle("after hold");

        // random traffic
        for (int n = 0; n < 60; n++) begin
            logic w, io, hm;
            w  = 1'($urandom);
            io = 1'($urandom);
            hm = ($urandom_range(0, 7) == 0);
            run_cycle(w, io, 20'($urandom), 16'($urandom), $urandom_range(0, 3),
                      16'($urandom), hm);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule